// File: doc/BRIEF.md
# Breakpoint Hit Status Collector

This block evaluates four debug slots in one cycle and folds the result into a debug status register that it owns. Each slot is either an instruction-address slot, which compares its address register with the current instruction pointer, or a data-watch slot, which takes a hit flag raised by separate access-detection logic. Slots of the port-I/O type are matched elsewhere and never hit here.

A slot that matches always sets its bit in the candidate status value, even when the slot is disabled. That value is written back only when an enabled slot matched or the caller forces the update. In every other case the old status is kept. The registered hit-enabled flag tells the exception logic whether an enabled slot fired.

The caller presents the control word, the slot addresses, the instruction pointer, the watch flags and the force input, and pulses the evaluate strobe. Both outputs are valid on the cycle after the strobe.

Top module: `dbg_hit_collect`

## Requirements
- R1: During and after reset, status_o equals the parameter RESET_VAL (default 32'hFFFF_0FF0) and hit_en_o is 0.
- R2: Slot i counts as enabled when control bit 2i (local enable) or control bit 2i+1 (global enable) is 1. Either bit alone is enough.
- R3: The 2-bit type of slot i is control bits [17+4i:16+4i]. The codes are 0 for instruction execute, 1 for data write, 2 for port I/O and 3 for data read/write. Bits [19+4i:18+4i] (length) and bits [15:8] have no effect.
- R4: An instruction-type slot matches only when its address equals ip_i in every bit, and it ignores its watch flag.
- R5: A data-write or data-read/write slot matches when its watch_hit_i bit is 1. A port-I/O slot never matches.
- R6: When the status is written, bits [3:0] take the set of matching slots (bit i for slot i), enabled or not. Bits above 3 keep their previous value.
- R7: On an evaluate strobe, the status is written only when an enabled slot matched or force_i is 1. Otherwise it stays unchanged.
- R8: On the cycle after an evaluate strobe, hit_en_o is 1 exactly when at least one matching slot is enabled.
- R9: Without an evaluate strobe, neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: enables, types and lengths per slot |
| slot_addr_i | input | 128 | Four slot addresses, slot i at bits [32i+31:32i] |
| ip_i | input | 32 | Current instruction pointer |
| watch_hit_i | input | 4 | Per-slot data-watch hit flags |
| force_i | input | 1 | Write status even without an enabled hit |
| eval_i | input | 1 | Evaluate strobe |
| status_o | output | 32 | Debug status register |
| hit_en_o | output | 1 | An enabled slot hit on the last evaluation |

## Verification
The bench targets the split between recording a hit and committing it. In one case a disabled slot matches with no force: a design that commits anyway changes the low status bits. In another, all slots miss under force: a design that skips the clear leaves stale bits behind. It also sets the watch flag on instruction-type and port-type slots, so a design that decodes the type field wrongly reports a hit that should not happen. It uses an instruction pointer one off from the slot address, so a design that compares only part of the address shows a false match. Each enable bit is exercised on its own, and the upper status bits are watched throughout, so a design that overwrites the whole word is caught.

// File: rtl/dbg_hit_pkg.sv
package dbg_hit_pkg;
  typedef enum logic [1:0] {
    BP_EXEC = 2'd0,
    BP_DWR  = 2'd1,
    BP_PORT = 2'd2,
    BP_DRW  = 2'd3
  } bp_kind_e;

  localparam int unsigned EN_STEP    = 2;
  localparam int unsigned TYPE_BASE  = 16;
  localparam int unsigned FIELD_STEP = 4;
endpackage

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
  import dbg_hit_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [1:0]        en_pair_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic              watch_i,
  output logic              match_o,
  output logic              enabled_o
);
  bp_kind_e kind;

  assign kind      = bp_kind_e'(kind_i);
  assign enabled_o = |en_pair_i;

  always_comb begin
    unique case (kind)
      BP_EXEC:        match_o = (addr_i == ip_i);
      BP_DWR, BP_DRW: match_o = watch_i;
      default:        match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_status_build.sv
module dbg_status_build #(
  parameter int unsigned           NUM_SLOTS = 4,
  parameter int unsigned           STAT_W    = 32,
  parameter logic [STAT_W-1:0]     RESET_VAL = 32'hFFFF_0FF0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 eval_i,
  input  logic                 force_i,
  input  logic [NUM_SLOTS-1:0] match_i,
  input  logic [NUM_SLOTS-1:0] enabled_i,
  output logic [STAT_W-1:0]    status_o,
  output logic                 hit_en_o
);
  localparam int unsigned HI_W = STAT_W - NUM_SLOTS;

  logic [STAT_W-1:0] status_q, status_next;
  logic              hit_en_q, any_en_hit, commit;

  assign any_en_hit  = |(match_i & enabled_i);
  assign commit      = eval_i && (any_en_hit || force_i);
  // clear low slot bits, then OR in every match regardless of enable
  assign status_next = {status_q[STAT_W-1:NUM_SLOTS], match_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= RESET_VAL;
      hit_en_q <= 1'b0;
    end else if (eval_i) begin
      hit_en_q <= any_en_hit;
      if (commit) status_q <= status_next;
    end
  end

  assign status_o = status_q;
  assign hit_en_o = hit_en_q;

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> ($stable(status_o) && $stable(hit_en_o)));

  assert_upper_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> (status_o[STAT_W-1 -: HI_W] == $past(status_o[STAT_W-1 -: HI_W])));

  assert_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !force_i) |=> (hit_en_o || $stable(status_o)));

  assert_hit_marks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> (!hit_en_o || (status_o[NUM_SLOTS-1:0] != '0)));
endmodule

// File: rtl/dbg_hit_collect.sv
module dbg_hit_collect
  import dbg_hit_pkg::*;
#(
  parameter int unsigned       NUM_SLOTS = 4,
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       STAT_W    = 32,
  parameter logic [STAT_W-1:0] RESET_VAL = 32'hFFFF_0FF0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [TYPE_BASE+FIELD_STEP*NUM_SLOTS-1:0] ctrl_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_i,
  input  logic [ADDR_W-1:0]           ip_i,
  input  logic [NUM_SLOTS-1:0]        watch_hit_i,
  input  logic                        force_i,
  input  logic                        eval_i,
  output logic [STAT_W-1:0]           status_o,
  output logic                        hit_en_o
);
  localparam int unsigned EN_W = EN_STEP * NUM_SLOTS;

  logic [NUM_SLOTS-1:0]   match_vec, en_vec, is_port;
  logic [2*NUM_SLOTS-1:0] len_bits;
  logic                   unused_ctrl;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int unsigned TPOS = TYPE_BASE + FIELD_STEP * g;
    dbg_slot_match #(.ADDR_W(ADDR_W)) u_match (
      .en_pair_i (ctrl_i[EN_STEP*g +: 2]),
      .kind_i    (ctrl_i[TPOS +: 2]),
      .addr_i    (slot_addr_i[ADDR_W*g +: ADDR_W]),
      .ip_i      (ip_i),
      .watch_i   (watch_hit_i[g]),
      .match_o   (match_vec[g]),
      .enabled_o (en_vec[g])
    );
    assign len_bits[2*g +: 2] = ctrl_i[TPOS+2 +: 2];
    assign is_port[g]         = (ctrl_i[TPOS +: 2] == BP_PORT);
  end

  assign unused_ctrl = ^{len_bits, ctrl_i[TYPE_BASE-1:EN_W]};

  dbg_status_build #(
    .NUM_SLOTS (NUM_SLOTS),
    .STAT_W    (STAT_W),
    .RESET_VAL (RESET_VAL)
  ) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eval_i    (eval_i),
    .force_i   (force_i),
    .match_i   (match_vec),
    .enabled_i (en_vec),
    .status_o  (status_o),
    .hit_en_o  (hit_en_o)
  );

  assert_port_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !force_i && (&is_port)) |=> (!hit_en_o && $stable(status_o)));

  assert_exec_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && ctrl_i[0] && ctrl_i[TYPE_BASE +: 2] == BP_EXEC
     && slot_addr_i[ADDR_W-1:0] == ip_i) |=> (hit_en_o && status_o[0]));
endmodule

// File: tb/sim_dbg_hit_collect.sv
module sim_dbg_hit_collect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic [127:0] slot_addr_i;
  logic [31:0] ip_i = '0;
  logic [3:0]  watch_hit_i = '0;
  logic        force_i = 1'b0;
  logic        eval_i = 1'b0;
  logic [31:0] status_o;
  logic        hit_en_o;

  int checks = 0;
  int errors = 0;
  localparam logic [27:0] UPPER = 28'hFFFF_0FF;

  always #5 clk_i = ~clk_i;

  dbg_hit_collect u0 (.*);

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] ip;
    logic [3:0]  watch;
    logic        frc;
    logic [3:0]  exp_low;
    logic        exp_hit;
  } vec_t;

  // slot addresses: 0x1000, 0x2000, 0x3000, 0x4000
  localparam vec_t VECS [11] = '{
    '{32'h0000_0001, 32'h1000, 4'b0000, 1'b0, 4'b0001, 1'b1}, // R4 R2 local enable
    '{32'h0000_0001, 32'h2000, 4'b0000, 1'b0, 4'b0001, 1'b0}, // R7 disabled match, no write
    '{32'h0000_0001, 32'h3000, 4'b0000, 1'b1, 4'b0100, 1'b0}, // R6 R7 forced, disabled bit set
    '{32'h0000_0008, 32'h2000, 4'b0000, 1'b0, 4'b0010, 1'b1}, // R2 global enable
    '{32'h0231_0055, 32'h9999, 4'b1111, 1'b0, 4'b0011, 1'b1}, // R3 R5 watch on data only
    '{32'h0231_0055, 32'h4000, 4'b0000, 1'b0, 4'b1000, 1'b1}, // R4 slot3 exec
    '{32'h0231_0000, 32'h4000, 4'b1111, 1'b0, 4'b1000, 1'b0}, // R7 none enabled
    '{32'h0231_0000, 32'h4000, 4'b1111, 1'b1, 4'b1011, 1'b0}, // R6 forced
    '{32'h0231_0020, 32'h3000, 4'b0100, 1'b0, 4'b1011, 1'b0}, // R5 port slot never hits
    '{32'hFF31_FF02, 32'h0000, 4'b0001, 1'b0, 4'b0001, 1'b1}, // R3 length and spare bits ignored
    '{32'h0000_00FF, 32'h1001, 4'b1111, 1'b1, 4'b0000, 1'b0}  // R4 off by one, forced clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_eval(input logic [31:0] c, input logic [31:0] ip,
                          input logic [3:0] w, input logic f);
    @(negedge clk_i);
    ctrl_i = c; ip_i = ip; watch_hit_i = w; force_i = f; eval_i = 1'b1;
    @(negedge clk_i);
    eval_i = 1'b0;
  endtask

  initial begin
    slot_addr_i = {32'h4000, 32'h3000, 32'h2000, 32'h1000};
    repeat (2) @(negedge clk_i);
    check("R1 status", status_o, 32'hFFFF_0FF0);
    check("R1 hit", {31'b0, hit_en_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < 11; i++) begin
      run_eval(VECS[i].ctrl, VECS[i].ip, VECS[i].watch, VECS[i].frc);
      check($sformatf("R6 R7 low vec%0d", i), {28'b0, status_o[3:0]}, {28'b0, VECS[i].exp_low});
      check($sformatf("R8 hit vec%0d", i), {31'b0, hit_en_o}, {31'b0, VECS[i].exp_hit});
      check($sformatf("R6 upper vec%0d", i), {4'b0, status_o[31:4]}, {4'b0, UPPER});
    end

    // R9: matching inputs without a strobe change nothing
    run_eval(32'h0000_0003, 32'h1000, 4'b0000, 1'b0);
    check("R2 both enables", status_o, 32'hFFFF_0FF1);
    @(negedge clk_i);
    ctrl_i = 32'h0000_0004; ip_i = 32'h2000; force_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R9 status hold", status_o, 32'hFFFF_0FF1);
    check("R9 hit hold", {31'b0, hit_en_o}, 32'h1);
    force_i = 1'b0;

    // R5: watch flag on exec-type slot ignored
    run_eval(32'h0000_0055, 32'h8888, 4'b1111, 1'b0);
    check("R5 exec ignores watch", {31'b0, hit_en_o}, 32'h0);
    check("R5 exec ignores watch status", status_o, 32'hFFFF_0FF1);

    // R1: reset mid-run restores defaults
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 re-reset status", status_o, 32'hFFFF_0FF0);
    check("R1 re-reset hit", {31'b0, hit_en_o}, 32'h0);
    rst_ni = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule